// File: doc/BRIEF.md
# Complementary Triangle Carrier Pair Generator

This block turns a fast system clock into two symmetric triangular carriers for a pulse-width modulator. Each carrier is an up/down counter that climbs one step per enabled clock to the top of its range, turns round, and falls one step per clock back to zero. The first carrier (M-shaped) starts at zero and rises. The second (W-shaped) starts at full scale and falls, so at every instant it is the mirror image of the first. Downstream comparators match each carrier against a modulation reference. Comparison, dead time and gate drive are outside this block.

The counter width sets the amplitude resolution and the carrier period. With width n, one full triangle takes 2·(2^n − 1) enabled clocks. With the default width of 8 that is 510 clocks, so a 9.8 MHz clock gives a carrier of about 19.2 kHz. Each counter keeps its direction in a JK-style flip-flop. The flip-flop is cleared when the count steps onto its top value and set when it steps onto zero, so each end value lasts exactly one sample. Two strobes mark the peak and the valley of the M carrier, and a downstream sampler can use them as trigger points. An enable input freezes the whole generator without losing its phase.

Top module: `tri_carrier_gen`

## Requirements
- R1: While reset is active, the M carrier reads 0, the W carrier reads 2^WIDTH − 1 (255 by default), and both strobes are low.
- R2: On each enabled clock, the M carrier changes by exactly one step. After reset it counts upward first.
- R3: When the M carrier reaches 255 it stays there for exactly one enabled clock, and the next enabled clock gives 254. It never wraps to 0.
- R4: When the M carrier falls to 0 it stays there for exactly one enabled clock, and the next enabled clock gives 1. It never wraps to 255.
- R5: Successive peaks of the M carrier are exactly 2·(2^WIDTH − 1) enabled clocks apart, which is 510 for the default width.
- R6: On every clock, the W carrier equals 255 minus the M carrier (its bitwise complement).
- R7: While the enable is low, both carriers hold their values and both counters keep their direction. When the enable returns, counting continues in the same direction.
- R8: The peak strobe (peak_stb) is high for one clock in the cycle where an enabled step has just brought the M carrier to 255. It is low at every other time, including the cycles where the enable is low and the count is held at 255.
- R9: The valley strobe (valley_stb) is high for one clock in the cycle where an enabled step has just brought the M carrier to 0. It is not raised by reset.
- R10: The peak and valley strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. It is asserted asynchronously and released synchronously inside the block. |
| en | input | 1 | Count enable. When it is low, the carriers and their directions are frozen. |
| carrier_m | output | WIDTH | M-shaped triangle carrier, starts at 0 and rises first |
| carrier_w | output | WIDTH | W-shaped triangle carrier, the complement of carrier_m |
| peak_stb | output | 1 | One-clock pulse when carrier_m has stepped onto its maximum |
| valley_stb | output | 1 | One-clock pulse when carrier_m has stepped onto zero |

## Verification
The bound checker checks the following on every cycle:
- the complement relation between the two carriers;
- the single-step motion under enable and the freeze when the enable is low;
- the turn-round at both ends, with no repeated end sample and no wrap;
- the pairing of each strobe with its end value;
- the one-cycle width of the strobes and the fact that the two strobes never coincide.

Some behaviour only shows up across a whole run, so only the bench's scenarios can show it:
- the exact period between peaks;
- that the counters start rising after reset;
- that the direction survives long enable gaps placed on an end value;
- that reset raises no strobe.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  // Count direction held by each carrier's JK-style flip-flop.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Number of carriers produced: index 0 is M-shaped, index 1 is W-shaped.
  localparam int unsigned NUM_CARRIERS = 2;

endpackage

// File: rtl/tcg_rst_sync.sv
module tcg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/tcg_updown.sv
module tcg_updown #(
  parameter int unsigned          WIDTH   = 8,
  parameter logic [WIDTH-1:0]     RST_VAL = '0,
  parameter tcg_pkg::dir_e        RST_DIR = tcg_pkg::DIR_UP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] cnt,
  output logic             hit_max,
  output logic             hit_min
);
  import tcg_pkg::*;

  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_MIN = '0;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  dir_e             dir_q;
  dir_e             dir_d;
  logic             jk_j;
  logic             jk_k;

  // Next count: one step in the held direction, only when enabled.
  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (dir_q == DIR_UP) begin
        cnt_d = cnt_q + CNT_ONE;
      end else begin
        cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  // J sets the direction to up when stepping onto the bottom,
  // K clears it to down when stepping onto the top.
  always_comb begin
    jk_k = en && (dir_q == DIR_UP)   && (cnt_d == CNT_MAX);
    jk_j = en && (dir_q == DIR_DOWN) && (cnt_d == CNT_MIN);
    unique case ({jk_j, jk_k})
      2'b10:   dir_d = DIR_UP;
      2'b01:   dir_d = DIR_DOWN;
      2'b11:   dir_d = (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
      default: dir_d = dir_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
      dir_q <= RST_DIR;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt     = cnt_q;
  assign hit_max = jk_k;
  assign hit_min = jk_j;

endmodule

// File: rtl/tcg_strobe.sv
module tcg_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic m_hit_max,
  input  logic m_hit_min,
  input  logic w_hit_max,
  input  logic w_hit_min,
  output logic peak_stb,
  output logic valley_stb
);

  logic peak_q;
  logic peak_d;
  logic valley_q;
  logic valley_d;

  // A strobe fires only when both carriers agree on the turn-round.
  always_comb begin
    peak_d   = m_hit_max && w_hit_min;
    valley_d = m_hit_min && w_hit_max;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q   <= 1'b0;
      valley_q <= 1'b0;
    end else begin
      peak_q   <= peak_d;
      valley_q <= valley_d;
    end
  end

  assign peak_stb   = peak_q;
  assign valley_stb = valley_q;

endmodule

// File: rtl/tri_carrier_gen.sv
module tri_carrier_gen #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] carrier_m,
  output logic [WIDTH-1:0] carrier_w,
  output logic             peak_stb,
  output logic             valley_stb
);
  import tcg_pkg::*;

  localparam logic [WIDTH-1:0] FULL_SCALE = {WIDTH{1'b1}};

  logic                         rst_sync_n;
  logic [NUM_CARRIERS-1:0][WIDTH-1:0] cnt_all;
  logic [NUM_CARRIERS-1:0]      hit_max_all;
  logic [NUM_CARRIERS-1:0]      hit_min_all;

  tcg_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // Carrier 0 rises from zero (M shape); carrier 1 falls from full scale (W shape).
  for (genvar gi = 0; gi < NUM_CARRIERS; gi++) begin : g_carrier
    localparam logic [WIDTH-1:0] START_VAL = (gi == 0) ? '0 : FULL_SCALE;
    localparam dir_e             START_DIR = (gi == 0) ? DIR_UP : DIR_DOWN;

    tcg_updown #(
      .WIDTH   (WIDTH),
      .RST_VAL (START_VAL),
      .RST_DIR (START_DIR)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en      (en),
      .cnt     (cnt_all[gi]),
      .hit_max (hit_max_all[gi]),
      .hit_min (hit_min_all[gi])
    );
  end

  tcg_strobe u_strobe (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .m_hit_max  (hit_max_all[0]),
    .m_hit_min  (hit_min_all[0]),
    .w_hit_max  (hit_max_all[1]),
    .w_hit_min  (hit_min_all[1]),
    .peak_stb   (peak_stb),
    .valley_stb (valley_stb)
  );

  assign carrier_m = cnt_all[0];
  assign carrier_w = cnt_all[1];

endmodule

// File: rtl/tcg_checker.sv
module tcg_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             en,
  input logic [WIDTH-1:0] carrier_m,
  input logic [WIDTH-1:0] carrier_w,
  input logic             peak_stb,
  input logic             valley_stb
);

  localparam logic [WIDTH-1:0] C_ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] C_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] C_MIN = '0;

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_q_n)
    carrier_w == ~carrier_m); // R6

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    en |=> ((WIDTH'(carrier_m - $past(carrier_m)) == C_ONE) ||
            (WIDTH'($past(carrier_m) - carrier_m) == C_ONE))); // R2

  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && carrier_m == C_MAX) |=> (carrier_m == C_MAX - C_ONE)); // R3

  AST_TURN_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && carrier_m == C_MIN) |=> (carrier_m == C_ONE)); // R4

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en |=> ($stable(carrier_m) && $stable(carrier_w))); // R7

  AST_PEAK_AT_TOP: assert property (@(posedge clk) disable iff (!rst_q_n)
    peak_stb |-> (carrier_m == C_MAX)); // R8

  AST_PEAK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    peak_stb |=> !peak_stb); // R8

  AST_VALLEY_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_q_n)
    valley_stb |-> (carrier_m == C_MIN)); // R9

  AST_VALLEY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    valley_stb |=> !valley_stb); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones({peak_stb, valley_stb}) <= 1); // R10

endmodule

bind tri_carrier_gen tcg_checker #(
  .WIDTH (WIDTH)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_sync_n),
  .en         (en),
  .carrier_m  (carrier_m),
  .carrier_w  (carrier_w),
  .peak_stb   (peak_stb),
  .valley_stb (valley_stb)
);

// File: tb/tri_carrier_gen_tb.sv
module tri_carrier_gen_tb;

  localparam int unsigned W      = 8;
  localparam int          TOP    = (1 << W) - 1;
  localparam int          PERIOD = 2 * TOP;

  logic         clk;
  logic         rst_n;
  logic         en;
  logic [W-1:0] carrier_m;
  logic [W-1:0] carrier_w;
  logic         peak_stb;
  logic         valley_stb;

  int n_checks;
  int n_fails;
  bit finished;

  // Reference model state: the values the outputs should show after the next edge.
  int m_exp;
  bit up_exp;
  bit peak_exp;
  bit valley_exp;
  bit prev_en;
  int en_steps;
  int last_peak;

  tri_carrier_gen #(.WIDTH(W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .carrier_m  (carrier_m),
    .carrier_w  (carrier_w),
    .peak_stb   (peak_stb),
    .valley_stb (valley_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int next_val(input int m, input bit up);
    return up ? m + 1 : m - 1;
  endfunction

  function automatic string m_tag(input int m, input bit was_en);
    if (!was_en)   return "R7";
    if (m == TOP)  return "R3";
    if (m == 0)    return "R4";
    return "R2";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(m_tag(m_exp, prev_en), int'(carrier_m), m_exp);
    chk("R6", int'(carrier_w), TOP - m_exp);
    chk("R8", int'(peak_stb), int'(peak_exp));
    chk("R9", int'(valley_stb), int'(valley_exp));
    chk("R10", int'(peak_stb && valley_stb), 0);
    if (peak_stb) begin
      if (last_peak >= 0) chk("R5", en_steps - last_peak, PERIOD);
      last_peak = en_steps;
    end
  endtask

  // Checks the current outputs at a falling edge, drives en, and advances the model.
  task automatic cycle(input bit en_v);
    @(negedge clk);
    check_outputs();
    en      = en_v;
    prev_en = en_v;
    peak_exp   = 1'b0;
    valley_exp = 1'b0;
    if (en_v) begin
      m_exp = next_val(m_exp, up_exp);
      en_steps++;
      if (up_exp && m_exp == TOP) begin
        peak_exp = 1'b1;
        up_exp   = 1'b0;
      end else if (!up_exp && m_exp == 0) begin
        valley_exp = 1'b1;
        up_exp     = 1'b1;
      end
    end
  endtask

  initial begin
    n_checks = 0; n_fails = 0; finished = 0;
    m_exp = 0; up_exp = 1'b1; peak_exp = 0; valley_exp = 0;
    prev_en = 0; en_steps = 0; last_peak = -1;
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    en    = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", int'(carrier_m), 0);
    chk("R1", int'(carrier_w), TOP);
    chk("R1", int'(peak_stb), 0);
    chk("R1", int'(valley_stb), 0);
    rst_n = 1'b1;
    // Let the internal reset release with the enable low (R9: no strobe from reset).
    for (int i = 0; i < 4; i++) cycle(1'b0);
    // Directed: free-running for over two periods (R2, R3, R4, R5).
    for (int i = 0; i < 1100; i++) cycle(1'b1);
    // Directed: freeze on the peak, then resume (R7, R8).
    while (m_exp != TOP) cycle(1'b1);
    for (int i = 0; i < 5; i++) cycle(1'b0);
    for (int i = 0; i < 3; i++) cycle(1'b1);
    // Directed: freeze on the valley, then resume (R7, R9).
    while (m_exp != 0) cycle(1'b1);
    for (int i = 0; i < 5; i++) cycle(1'b0);
    for (int i = 0; i < 3; i++) cycle(1'b1);
    // Random enable pattern.
    for (int i = 0; i < 3000; i++) cycle(1'($urandom_range(0, 1)));
    // Mostly enabled, sparse gaps.
    for (int i = 0; i < 2000; i++) cycle(($urandom_range(0, 9) != 0));
    @(negedge clk);
    check_outputs();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule